// File: doc/BRIEF.md
# Direct and Absolute Data Address Generator

This block forms the 23-bit data-memory address for the operand modes of a load/store unit that do not use a pointer register. A 7-bit high part and a 16-bit low part make up each address. In direct mode, an instruction offset is added to a base. A status bit picks the base: the stack base (SPH:SP) or the data-page base (DPH:DP). A qualifier can override that choice and force the register page at address zero. Two absolute modes also exist. The short form places a 16-bit constant under the page high part. The long form uses a 23-bit constant unchanged.

Each request carries a mode, an operand, the status bit, the qualifier and the four base register values. It enters on a valid/ready handshake. The result leaves one cycle later on a second valid/ready handshake, together with a flag that is set when the address lands in the memory-mapped register window 000000h..00005Fh.

A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained that cycle. While `out_valid` is high and `out_ready` is low, the output stage holds its content and no new request is taken.

Top module: `agen_direct_abs`

## Requirements
- R1: Mode 2'b00 (direct) with `in_cpl`=1 and `in_mmap`=0 gives {sph, sp + opnd[15:0]}. For example, sph=00h, sp=FF00h and offset 0005h give 00FF05h.
- R2: Mode 2'b00 with `in_cpl`=0 and `in_mmap`=0 gives {dph, dp + opnd[15:0]}, and the stack values have no effect. For example, dph=03h, dp=0000h and offset 0005h give 030005h.
- R3: The direct low-part sum wraps modulo 2^16, and a carry never changes the high part. For example, sph=05h, sp=FFFEh and offset 0005h give 050003h.
- R4: Mode 2'b01 (short absolute) gives {dph, opnd[15:0]}. `in_cpl`, `in_mmap`, sph, sp and dp have no effect. For example, dph=03h with 2002h gives 032002h.
- R5: Modes 2'b10 and 2'b11 (long absolute) give opnd[22:0] unchanged, whatever the other inputs are.
- R6: Mode 2'b00 with `in_mmap`=1 gives {7'h00, opnd[15:0]}, whatever the value of `in_cpl` and of the base registers.
- R7: `out_mmr` is 1 exactly when `out_addr` is at most 00005Fh. So 00005Fh gives 1 and 000060h gives 0.
- R8: A request accepted on a rising edge appears on `out_valid`/`out_addr`/`out_mmr` right after that edge, which is a latency of one cycle.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_addr`/`out_mmr` stay unchanged. `in_ready` equals !out_valid || out_ready.
- R10: After reset, `out_valid`, `out_addr` and `out_mmr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_mode | input | 2 | 00 direct, 01 short absolute, 10/11 long absolute |
| in_opnd | input | 23 | Offset or constant (low 16 bits used except in long absolute mode) |
| in_cpl | input | 1 | Direct base select: 1 stack, 0 data page |
| in_mmap | input | 1 | Force direct access onto the register page |
| in_dph | input | 7 | Data page high part |
| in_dp | input | 16 | Data page low part |
| in_sph | input | 7 | Stack high part |
| in_sp | input | 16 | Stack pointer |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 23 | Effective address |
| out_mmr | output | 1 | Address is in the register window |

## Verification
In a single request, the register-page override and the stack-base selection can both apply. The bench sets `in_cpl`=1 and `in_mmap`=1 with a nonzero stack base, and requires that the result is the bare offset with the register-hit flag set correctly at both edges of the window. Back-pressure and a new request can also meet in one cycle. The bench stalls the output, offers a second request while the first is held, and then releases the stall. It checks that the first result stays stable and that the second appears exactly one cycle after release.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_ABS16  = 2'b01,
    MODE_ABS23  = 2'b10,
    MODE_ABS23X = 2'b11
  } agen_mode_e;

  localparam int DEF_HI_W     = 7;
  localparam int DEF_LO_W     = 16;
  localparam int DEF_MMR_LAST = 'h5F;
endpackage

// File: rtl/agen_base_sel.sv
module agen_base_sel
  import agen_pkg::*;
#(
  parameter int HI_W = DEF_HI_W,
  parameter int LO_W = DEF_LO_W
) (
  input  agen_mode_e       mode,
  input  logic             cpl,
  input  logic             mmap,
  input  logic [HI_W-1:0]  dph,
  input  logic [LO_W-1:0]  dp,
  input  logic [HI_W-1:0]  sph,
  input  logic [LO_W-1:0]  sp,
  output logic [HI_W-1:0]  base_hi,
  output logic [LO_W-1:0]  base_lo,
  output logic             pass_full
);
  // Short absolute is expressed as page base {dph, 0} plus the constant.
  always_comb begin
    base_hi   = '0;
    base_lo   = '0;
    pass_full = 1'b0;
    unique case (mode)
      MODE_DIRECT: begin
        if (mmap) begin
          base_hi = '0;
          base_lo = '0;
        end else if (cpl) begin
          base_hi = sph;
          base_lo = sp;
        end else begin
          base_hi = dph;
          base_lo = dp;
        end
      end
      MODE_ABS16: begin
        base_hi = dph;
        base_lo = '0;
      end
      default: pass_full = 1'b1;
    endcase
  end
endmodule

// File: rtl/agen_compose.sv
module agen_compose
  import agen_pkg::*;
#(
  parameter int HI_W = DEF_HI_W,
  parameter int LO_W = DEF_LO_W,
  localparam int ADDR_W = HI_W + LO_W
) (
  input  logic [HI_W-1:0]   base_hi,
  input  logic [LO_W-1:0]   base_lo,
  input  logic              pass_full,
  input  logic [ADDR_W-1:0] opnd,
  output logic [ADDR_W-1:0] addr
);
  logic [LO_W-1:0] lo_sum;

  // Modulo 2^LO_W: the carry out is dropped on purpose.
  assign lo_sum = base_lo + opnd[LO_W-1:0];
  assign addr   = pass_full ? opnd : {base_hi, lo_sum};
endmodule

// File: rtl/agen_mmr_detect.sv
module agen_mmr_detect
  import agen_pkg::*;
#(
  parameter int ADDR_W   = DEF_HI_W + DEF_LO_W,
  parameter int MMR_LAST = DEF_MMR_LAST
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MMR_LAST);

  generate
    if (MMR_LAST < 0) begin : g_none
      assign hit = 1'b0;
    end else if (MMR_LAST == 0) begin : g_zero
      assign hit = (addr == '0);
    end else begin : g_range
      assign hit = (addr <= LAST);
    end
  endgenerate
endmodule

// File: rtl/agen_direct_abs.sv
module agen_direct_abs
  import agen_pkg::*;
#(
  parameter int HI_W     = DEF_HI_W,
  parameter int LO_W     = DEF_LO_W,
  parameter int MMR_LAST = DEF_MMR_LAST,
  localparam int ADDR_W  = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [ADDR_W-1:0] in_opnd,
  input  logic              in_cpl,
  input  logic              in_mmap,
  input  logic [HI_W-1:0]   in_dph,
  input  logic [LO_W-1:0]   in_dp,
  input  logic [HI_W-1:0]   in_sph,
  input  logic [LO_W-1:0]   in_sp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_mmr
);
  logic [HI_W-1:0]   base_hi;
  logic [LO_W-1:0]   base_lo;
  logic              pass_full;
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_mmr;
  agen_mode_e        mode;

  assign mode = agen_mode_e'(in_mode);

  agen_base_sel #(.HI_W(HI_W), .LO_W(LO_W)) u_base (
    .mode      (mode),
    .cpl       (in_cpl),
    .mmap      (in_mmap),
    .dph       (in_dph),
    .dp        (in_dp),
    .sph       (in_sph),
    .sp        (in_sp),
    .base_hi   (base_hi),
    .base_lo   (base_lo),
    .pass_full (pass_full)
  );

  agen_compose #(.HI_W(HI_W), .LO_W(LO_W)) u_comp (
    .base_hi   (base_hi),
    .base_lo   (base_lo),
    .pass_full (pass_full),
    .opnd      (in_opnd),
    .addr      (nxt_addr)
  );

  agen_mmr_detect #(.ADDR_W(ADDR_W), .MMR_LAST(MMR_LAST)) u_mmr (
    .addr (nxt_addr),
    .hit  (nxt_mmr)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_mmr   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= nxt_addr;
        out_mmr  <= nxt_mmr;
      end
    end
  end
endmodule

// File: rtl/agen_direct_abs_chk.sv
module agen_direct_abs_chk #(
  parameter int HI_W     = 7,
  parameter int LO_W     = 16,
  parameter int MMR_LAST = 'h5F,
  localparam int ADDR_W  = HI_W + LO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_mode,
  input logic [ADDR_W-1:0] in_opnd,
  input logic [HI_W-1:0]   in_dph,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_mmr
);
  logic fire;
  assign fire = in_valid && in_ready;

  // R8
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_mmr)));

  a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mmr == (out_addr <= ADDR_W'(MMR_LAST))));

  // R5
  a_r5_long_abs: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_mode[1]) |=> (out_addr == $past(in_opnd)));

  // R4
  a_r4_short_abs: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_mode == 2'b01) |=> (out_addr == {$past(in_dph), $past(in_opnd[LO_W-1:0])}));
endmodule

bind agen_direct_abs agen_direct_abs_chk #(
  .HI_W(HI_W), .LO_W(LO_W), .MMR_LAST(MMR_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_opnd(in_opnd), .in_dph(in_dph),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_mmr(out_mmr)
);

// File: tb/agen_direct_abs_bench.sv
`timescale 1ns/1ps
module agen_direct_abs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'b00;
  logic [22:0] in_opnd = '0;
  logic        in_cpl = 1'b0;
  logic        in_mmap = 1'b0;
  logic [6:0]  in_dph = '0;
  logic [15:0] in_dp = '0;
  logic [6:0]  in_sph = '0;
  logic [15:0] in_sp = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [22:0] out_addr;
  logic        out_mmr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  agen_direct_abs u_agen_direct_abs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_opnd(in_opnd), .in_cpl(in_cpl), .in_mmap(in_mmap),
    .in_dph(in_dph), .in_dp(in_dp), .in_sph(in_sph), .in_sp(in_sp),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_mmr(out_mmr)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic set_regs(input logic [6:0] dph, input logic [15:0] dp,
                          input logic [6:0] sph, input logic [15:0] sp);
    in_dph = dph; in_dp = dp; in_sph = sph; in_sp = sp;
  endtask

  // Drive one request at a falling edge, let it be taken, check at the next falling edge.
  task automatic run(input string tag, input logic [1:0] mode, input logic [22:0] opnd,
                     input logic cpl, input logic mmap,
                     input logic [22:0] exp_addr, input logic exp_mmr);
    @(negedge clk);
    in_mode = mode; in_opnd = opnd; in_cpl = cpl; in_mmap = mmap; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " addr"}, {9'd0, out_addr}, {9'd0, exp_addr});
    check({tag, " mmr"}, {31'd0, out_mmr}, {31'd0, exp_mmr});
  endtask

  task automatic t_reset;
    check("R10 valid", {31'd0, out_valid}, 32'd0);
    check("R10 addr", {9'd0, out_addr}, 32'd0);
    check("R10 mmr", {31'd0, out_mmr}, 32'd0);
    check("R9 ready idle", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_stack;
    set_regs(7'h03, 16'h4000, 7'h00, 16'hFF00);
    run("R1 sp", 2'b00, 23'h000005, 1'b1, 1'b0, 23'h00FF05, 1'b0);
    set_regs(7'h55, 16'h0000, 7'h12, 16'h1234);
    run("R1 sp2", 2'b00, 23'h000010, 1'b1, 1'b0, 23'h121244, 1'b0);
  endtask

  task automatic t_page;
    set_regs(7'h03, 16'h0000, 7'h6A, 16'hABCD);
    run("R2 dp", 2'b00, 23'h000005, 1'b0, 1'b0, 23'h030005, 1'b0);
  endtask

  task automatic t_wrap;
    set_regs(7'h11, 16'h2222, 7'h05, 16'hFFFE);
    run("R3 sp wrap", 2'b00, 23'h000005, 1'b1, 1'b0, 23'h050003, 1'b0);
    set_regs(7'h7F, 16'hFFFF, 7'h00, 16'h0000);
    run("R3 dp wrap", 2'b00, 23'h00FFFF, 1'b0, 1'b0, 23'h7FFFFE, 1'b0);
  endtask

  task automatic t_abs16;
    set_regs(7'h03, 16'h9999, 7'h44, 16'h1111);
    run("R4 abs16", 2'b01, 23'h002002, 1'b1, 1'b1, 23'h032002, 1'b0);
    set_regs(7'h00, 16'h0100, 7'h00, 16'h0100);
    run("R4 abs16 low", 2'b01, 23'h00005F, 1'b0, 1'b0, 23'h00005F, 1'b1);
  endtask

  task automatic t_abs23;
    set_regs(7'h12, 16'h3456, 7'h78, 16'h9ABC);
    run("R5 abs23", 2'b10, 23'h032002, 1'b1, 1'b0, 23'h032002, 1'b0);
    run("R5 abs23 m3", 2'b11, 23'h7FFFFF, 1'b0, 1'b1, 23'h7FFFFF, 1'b0);
    run("R7 abs23 zero", 2'b10, 23'h000000, 1'b0, 1'b0, 23'h000000, 1'b1);
  endtask

  // Register-page override meeting the stack-base selection.
  task automatic t_mmap;
    set_regs(7'h22, 16'h7000, 7'h44, 16'h8000);
    run("R6 mmap stack", 2'b00, 23'h00005F, 1'b1, 1'b1, 23'h00005F, 1'b1);
    run("R7 mmap edge", 2'b00, 23'h000060, 1'b0, 1'b1, 23'h000060, 1'b0);
  endtask

  task automatic t_stall;
    set_regs(7'h01, 16'h0000, 7'h02, 16'h0000);
    @(negedge clk);
    out_ready = 1'b0;
    in_mode = 2'b10; in_opnd = 23'h012345; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 first", {9'd0, out_addr}, 32'h012345);
    check("R9 ready low", {31'd0, in_ready}, 32'd0);
    in_opnd = 23'h054321;
    @(posedge clk);
    @(negedge clk);
    check("R9 held addr", {9'd0, out_addr}, 32'h012345);
    check("R9 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second", {9'd0, out_addr}, 32'h054321);
    check("R8 second valid", {31'd0, out_valid}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stack();
    t_page();
    t_wrap();
    t_abs16();
    t_abs23();
    t_mmap();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule